// File: doc/BRIEF.md
# Dynamic On-Die Termination Controller

This block decides, every clock, what the DRAM-side termination does. The termination can be off, on at its nominal strength, or on at its write strength. The on/off decision follows the registered ODT pin. It is delayed by a turn-on latency and a turn-off latency, and both equal the write latency minus two cycles.

When dynamic termination is enabled in the mode registers, each registered write command opens a window that replaces the nominal strength with the write strength. The window opens a fixed number of cycles after the write. It closes at a later point, and that point depends on whether the write was a chopped burst of four or a full burst of eight.

The block is placed next to the command decoder. It receives a one-cycle write strobe with a chop flag, the current write latency, and the strength fields already held in the mode registers. It drives a termination-enable flag and a strength code to the pad control.

Top module: `odt_dyn_ctrl`

## Requirements
- R1: A low `rst_n` at a clock edge forces `term_en` and `term_code` to 0 after that edge and discards any pending write window. After release, the strength is nominal until a new write arrives.
- R2: When `odt_pin` is sampled high at edge k after having been low, `term_en` stays 0 through edge k+WL-3 and is 1 after edge k+WL-2.
- R3: When `odt_pin` is sampled low at edge k after having been high, `term_en` stays 1 through edge k+WL-3 and is 0 after edge k+WL-2.
- R4: While `term_en` is 1 and no write window is active, `term_code` equals `rtt_nom`.
- R5: While `term_en` is 0, `term_code` is 0.
- R6: Dynamic mode is enabled when either bit of `rtt_wr` is 1. While the write strength is selected, `term_code` equals `rtt_wr` zero-extended to the width of `rtt_nom`.
- R7: With dynamic mode enabled, for a write sampled at edge w, `term_code` is nominal through edge w+WL-3 and is the write strength after edge w+WL-2.
- R8: For a burst-of-eight write (`wr_bc4` = 0), the write strength holds through edge w+WL+3 and `term_code` is nominal again after edge w+WL+4.
- R9: For a chopped write (`wr_bc4` = 1), the write strength holds through edge w+WL+1 and `term_code` is nominal again after edge w+WL+2.
- R10: When `rtt_wr` is 0, a write strobe has no effect on `term_code`.
- R11: A write sampled while an earlier window is pending restarts the window timing from the new write. The write strength then lasts until the new write's closing latency, with no return to nominal in between.
- R12: Writes do not change `term_en`. A write with ODT low leaves `term_en` and `term_code` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| odt_pin | input | 1 | Registered ODT pin level |
| wr_cmd | input | 1 | One-cycle strobe for any decoded write command |
| wr_bc4 | input | 1 | 1 = chopped burst of four, 0 = burst of eight; valid with `wr_cmd` |
| wl | input | 4 | Write latency in cycles, 5 to 12; values outside this range are clamped |
| rtt_nom | input | 3 | Nominal strength code from mode register 1 |
| rtt_wr | input | 2 | Write strength code from mode register 2; nonzero enables dynamic mode |
| term_en | output | 1 | Termination enabled |
| term_code | output | 3 | Selected strength code, 0 when termination is off |

## Verification
The hardest case to reach is a second write landing inside a window that is already open. It must arrive after the write strength is selected but before the first window's closing edge, so that a wrong design would visibly drop back to nominal. The bench places the second write four cycles after the first and samples between the two possible closing edges. A second hard case is a reset that arrives during a pending window: the bench resets a few cycles after a write and then checks that the restored termination comes back at nominal strength. If the window were not discarded, the restored termination would appear inside the old window and show the write strength.

// File: rtl/odt_dyn_pkg.sv
// Package: shared types for the dynamic termination controller.
// Assumes: consumers only need the strength-select encoding.
package odt_dyn_pkg;

    // Which strength the output stage presents.
    typedef enum logic [1:0] {
        SEL_OFF = 2'd0,
        SEL_NOM = 2'd1,
        SEL_WRS = 2'd2
    } rtt_sel_e;

endpackage

// File: rtl/odt_onoff_delay.sv
// Module: odt_onoff_delay
// Delays the registered ODT level by a run-time latency and presents it
// as the termination-enable flag. Both edges use the same latency.
// Assumes: 1 <= lat <= DEPTH; larger values read as off.
module odt_onoff_delay #(
    parameter int DEPTH = 10,
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             odt_pin,
    input  logic [LAT_W-1:0] lat,
    output logic             term_en
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] hist;
    logic [LAT_W-1:0] tap;
    logic             tap_bit;

    // Pick the history bit captured lat-1 edges ago.
    always_comb begin
        tap     = lat - LAT_W'(1);
        tap_bit = 1'b0;
        if (32'(tap) < DEPTH) begin
            tap_bit = hist[IDX_W'(tap)];
        end
    end

    // Shift the ODT history and register the delayed level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist    <= '0;
            term_en <= 1'b0;
        end else begin
            hist    <= {hist[DEPTH-2:0], odt_pin};
            term_en <= tap_bit;
        end
    end

    // R2/R3: termination only turns on if ODT was high somewhere in the history.
    a_r2_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_en) |-> $past(hist != '0));

endmodule

// File: rtl/odt_write_window.sv
// Module: odt_write_window
// Times the write-strength window. A qualified write (re)starts a cycle
// counter. The window opens when the counter reaches the change-to-write
// latency and closes at the chop- or burst-dependent return latency.
// Assumes: lat >= 1 and lat stays constant while a window is pending.
module odt_write_window #(
    parameter int LAT_W     = 4,
    parameter int BC4_EXTRA = 4,
    parameter int BL8_EXTRA = 6,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmd,
    input  logic             wr_bc4,
    input  logic             dyn_en,
    input  logic [LAT_W-1:0] lat,
    output logic             wr_sel
);
    logic             active;
    logic             bc4_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] l_open;
    logic [CNT_W-1:0] l_close;

    // Derive the open and close counts from the latched burst type.
    always_comb begin
        l_open  = CNT_W'(lat);
        l_close = CNT_W'(lat) + (bc4_q ? CNT_W'(BC4_EXTRA) : CNT_W'(BL8_EXTRA));
    end

    // Count cycles since the last qualified write and steer the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            bc4_q  <= 1'b0;
            cnt    <= '0;
            wr_sel <= 1'b0;
        end else if (wr_cmd && dyn_en) begin
            active <= 1'b1;
            bc4_q  <= wr_bc4;
            cnt    <= CNT_W'(1);
        end else if (active) begin
            cnt <= cnt + CNT_W'(1);
            if (cnt == l_open) begin
                wr_sel <= 1'b1;
            end
            if (cnt == l_close) begin
                wr_sel <= 1'b0;
                active <= 1'b0;
                cnt    <= '0;
            end
        end
    end

    // R7: the write strength starts exactly at the change-to-write count.
    a_r7_open_at_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_sel) |-> ($past(cnt) == $past(l_open)));

    // R8/R9: the write strength ends exactly at the return count.
    a_r8_close_at_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_sel) |-> ($past(cnt) == $past(l_close)));

    // R11: the counter never runs past the closing count.
    a_r11_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt <= l_close));

    // R10: a write without dynamic mode does not open a window.
    a_r10_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !dyn_en && !active) |=> !active);

endmodule

// File: rtl/odt_code_mux.sv
// Module: odt_code_mux
// Selects the strength code shown at the output: zero when off, the write
// code while the write window is open with dynamic mode on, else nominal.
// Assumes: NOM_W >= WR_W; the write code is zero-extended.
module odt_code_mux
    import odt_dyn_pkg::*;
#(
    parameter int NOM_W = 3,
    parameter int WR_W  = 2
) (
    input  logic             term_en,
    input  logic             wr_sel,
    input  logic             dyn_en,
    input  logic [NOM_W-1:0] rtt_nom,
    input  logic [WR_W-1:0]  rtt_wr,
    output logic [NOM_W-1:0] term_code
);
    rtt_sel_e sel;

    // Decide which strength source is active.
    always_comb begin
        if (!term_en)              sel = SEL_OFF;
        else if (wr_sel && dyn_en) sel = SEL_WRS;
        else                       sel = SEL_NOM;
    end

    // Drive the code for the chosen source.
    always_comb begin
        case (sel)
            SEL_NOM: term_code = rtt_nom;
            SEL_WRS: term_code = NOM_W'(rtt_wr);
            default: term_code = '0;
        endcase
    end

endmodule

// File: rtl/odt_dyn_ctrl.sv
// Module: odt_dyn_ctrl (top)
// Dynamic on-die termination controller. It clamps the write latency,
// derives the common latency WL-2, and combines the delayed ODT level with
// the write-strength window into an enable flag and a strength code.
// Assumes: inputs are synchronous to clk; mode fields change only while idle.
module odt_dyn_ctrl #(
    parameter int WL_W      = 4,
    parameter int WL_MIN    = 5,
    parameter int WL_MAX    = 12,
    parameter int NOM_W     = 3,
    parameter int WR_W      = 2,
    parameter int BC4_EXTRA = 4,
    parameter int BL8_EXTRA = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             odt_pin,
    input  logic             wr_cmd,
    input  logic             wr_bc4,
    input  logic [WL_W-1:0]  wl,
    input  logic [NOM_W-1:0] rtt_nom,
    input  logic [WR_W-1:0]  rtt_wr,
    output logic             term_en,
    output logic [NOM_W-1:0] term_code
);
    localparam int DEPTH = WL_MAX - 2;
    localparam int CNT_W = $clog2(DEPTH + BL8_EXTRA + BC4_EXTRA + 1);

    logic [WL_W-1:0] wl_c;
    logic [WL_W-1:0] lat;
    logic            dyn_en;
    logic            wr_sel;

    // Clamp the write latency to the supported range and derive WL-2.
    always_comb begin
        if (32'(wl) < WL_MIN)      wl_c = WL_W'(WL_MIN);
        else if (32'(wl) > WL_MAX) wl_c = WL_W'(WL_MAX);
        else                       wl_c = wl;
        lat = wl_c - WL_W'(2);
    end

    // Dynamic mode is on when the write strength field is nonzero.
    always_comb dyn_en = |rtt_wr;

    odt_onoff_delay #(
        .DEPTH (DEPTH),
        .LAT_W (WL_W)
    ) u_onoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .odt_pin (odt_pin),
        .lat     (lat),
        .term_en (term_en)
    );

    odt_write_window #(
        .LAT_W     (WL_W),
        .BC4_EXTRA (BC4_EXTRA),
        .BL8_EXTRA (BL8_EXTRA),
        .CNT_W     (CNT_W)
    ) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_cmd (wr_cmd),
        .wr_bc4 (wr_bc4),
        .dyn_en (dyn_en),
        .lat    (lat),
        .wr_sel (wr_sel)
    );

    odt_code_mux #(
        .NOM_W (NOM_W),
        .WR_W  (WR_W)
    ) u_mux (
        .term_en   (term_en),
        .wr_sel    (wr_sel),
        .dyn_en    (dyn_en),
        .rtt_nom   (rtt_nom),
        .rtt_wr    (rtt_wr),
        .term_code (term_code)
    );

    // R1: a reset edge leaves termination off and the window closed.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!term_en && !wr_sel));

    // R5: no strength code is presented while termination is off.
    a_r5_off_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !term_en |-> (term_code == '0));

endmodule

// File: tb/odt_dyn_ctrl_tb.sv
`timescale 1ns/1ps
module odt_dyn_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       odt_pin = 1'b0;
    logic       wr_cmd = 1'b0;
    logic       wr_bc4 = 1'b0;
    logic [3:0] wl = 4'd7;
    logic [2:0] rtt_nom = 3'b101;
    logic [1:0] rtt_wr = 2'b00;
    logic       term_en;
    logic [2:0] term_code;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    odt_dyn_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .odt_pin   (odt_pin),
        .wr_cmd    (wr_cmd),
        .wr_bc4    (wr_bc4),
        .wl        (wl),
        .rtt_nom   (rtt_nom),
        .rtt_wr    (rtt_wr),
        .term_en   (term_en),
        .term_code (term_code)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One-cycle write strobe; returns one negedge after the sampling edge.
    task automatic write_pulse(bit bc4);
        wr_cmd = 1'b1;
        wr_bc4 = bc4;
        step(1);
        wr_cmd = 1'b0;
    endtask

    // Bring termination on at nominal strength and let it settle.
    task automatic settle_on(int lat);
        odt_pin = 1'b1;
        step(lat + 3);
    endtask

    task automatic t_reset_state();
        check("R1 en after reset", term_en, 0);
        check("R1 code after reset", term_code, 0);
    endtask

    task automatic t_onoff(logic [3:0] w);
        int lat;
        wl = w;
        lat = int'(w) - 2;
        odt_pin = 1'b0;
        step(lat + 3);
        odt_pin = 1'b1;
        step(lat);
        check("R2 still off before latency", term_en, 0);
        step(1);
        check("R2 on at latency", term_en, 1);
        check("R4 nominal code", term_code, 5);
        step(2);
        odt_pin = 1'b0;
        step(lat);
        check("R3 still on before latency", term_en, 1);
        step(1);
        check("R3 off at latency", term_en, 0);
        check("R5 code zero when off", term_code, 0);
    endtask

    task automatic t_write(bit bc4, logic [1:0] wr_code);
        int lat;
        int hold;
        lat = int'(wl) - 2;
        hold = bc4 ? 4 : 6;
        rtt_wr = wr_code;
        settle_on(lat);
        write_pulse(bc4);
        step(lat - 1);
        check("R7 nominal before change", term_code, 5);
        step(1);
        check("R7 write strength at change R6", term_code, int'(wr_code));
        step(hold - 1);
        check(bc4 ? "R9 write strength held" : "R8 write strength held", term_code, int'(wr_code));
        step(1);
        check(bc4 ? "R9 back to nominal" : "R8 back to nominal", term_code, 5);
        step(4);
    endtask

    task automatic t_disabled();
        int lat;
        lat = int'(wl) - 2;
        rtt_wr = 2'b00;
        settle_on(lat);
        write_pulse(1'b0);
        step(lat);
        check("R10 no write strength when disabled", term_code, 5);
        step(3);
        check("R10 still nominal", term_code, 5);
        step(4);
    endtask

    task automatic t_restart();
        int lat;
        lat = int'(wl) - 2;
        rtt_wr = 2'b10;
        settle_on(lat);
        write_pulse(1'b0);
        step(3);
        write_pulse(1'b0);
        step(lat + 2);
        check("R11 held past first close", term_code, 2);
        step(3);
        check("R11 held to second close", term_code, 2);
        step(1);
        check("R11 nominal after second close", term_code, 5);
        step(4);
    endtask

    task automatic t_write_odt_low();
        int lat;
        lat = int'(wl) - 2;
        rtt_wr = 2'b01;
        odt_pin = 1'b0;
        step(lat + 3);
        write_pulse(1'b0);
        step(lat + 1);
        check("R12 en stays off", term_en, 0);
        check("R12 code stays zero", term_code, 0);
        step(8);
    endtask

    task automatic t_reset_mid_window();
        int lat;
        lat = int'(wl) - 2;
        rtt_wr = 2'b01;
        settle_on(lat);
        write_pulse(1'b0);
        rst_n = 1'b0;
        step(1);
        check("R1 en cleared by reset", term_en, 0);
        check("R1 code cleared by reset", term_code, 0);
        step(1);
        rst_n = 1'b1;
        step(lat + 1);
        check("R1 termination back on", term_en, 1);
        check("R1 window discarded", term_code, 5);
        step(8);
    endtask

    initial begin
        step(3);
        t_reset_state();
        rst_n = 1'b1;
        step(1);
        t_onoff(4'd7);
        t_onoff(4'd5);
        t_onoff(4'd12);
        wl = 4'd7;
        t_write(1'b0, 2'b01);
        t_write(1'b1, 2'b11);
        wl = 4'd10;
        t_write(1'b0, 2'b10);
        wl = 4'd7;
        t_disabled();
        t_restart();
        t_write_odt_low();
        t_reset_mid_window();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule